// File: doc/BRIEF.md
# Multi-Latency Writeback Hazard Controller

This block sits at the issue stage of an in-order pipeline. The pipeline has three execution sub-pipelines of different depths: integer (which also carries loads), floating-point add and floating-point multiply. All of them write into one shared register file that has a single write port. Integer and floating-point destinations share one register namespace.

The controller sees one candidate instruction per cycle and decides whether it may issue. It keeps two kinds of state. The first is a ring of writeback slots that records, for each future cycle, whether the write port is already booked and for which register. The second is a per-register countdown giving the number of cycles until that register's outstanding write lands.

A candidate is held back when its own writeback cycle is already booked, or when it would finish no later than an earlier write to the same register. Write-after-read needs no tracking, because operands are read in program order at decode. The current cycle's booked write is exposed on `wb_due`/`wb_reg`, so the register-file write port can be steered from it.

Top module: `hazard_issue_ctrl`

## Requirements
- R1: `issue_grant` is high exactly when `req_valid` is high and no hazard exists. `issue_stall` is high exactly when `req_valid` is high and a hazard exists. Both are low when `req_valid` is low, and both are decided combinationally in the same cycle.
- R2: `req_kind` encodes 0 = integer, 1 = load, 2 = FP add, 3 = FP multiply. An instruction granted in cycle c with a tracked destination raises `wb_due` with `wb_reg` equal to its destination in cycle c+L. L is 2 for integer, 3 for load, 5 for FP add and 8 for FP multiply.
- R3: A tracked candidate is stalled when the cycle in which its writeback would land is already booked by an earlier instruction.
- R4: A tracked candidate is stalled when its destination has an outstanding write that lands in the same cycle as, or later than, the candidate's own writeback.
- R5: A candidate whose writeback lands strictly after the outstanding write to the same register is granted, provided no other hazard applies. Once the earlier write has landed, the register no longer blocks anything.
- R6: The booked slots advance every cycle, including stall cycles. A request that is stalled in one cycle because of a slot conflict is granted in a later cycle once its own slot is free.
- R7: A candidate with `req_wen` low or with `req_dest` equal to 0 is always granted. It books no writeback slot and marks no register pending, so it never produces `wb_due` and never blocks later instructions.
- R8: Synchronous reset discards every booked slot and every pending count. After reset, `wb_due` stays low until new work is granted, and earlier destinations no longer block issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A candidate instruction is present at issue |
| req_kind | input | 2 | Execution path of the candidate (0 int, 1 load, 2 FP add, 3 FP mul) |
| req_wen | input | 1 | Candidate writes a destination register |
| req_dest | input | 5 | Destination register index |
| issue_grant | output | 1 | Candidate issues at the end of this cycle |
| issue_stall | output | 1 | Candidate is held at issue this cycle |
| wb_due | output | 1 | A booked writeback lands in this cycle |
| wb_reg | output | 5 | Destination of the writeback landing in this cycle |

## Verification
On every cycle, the assertions check the following properties:
- grant and stall are never high together, and neither is high when there is no request;
- a landing writeback never targets register 0;
- the cycle after reset carries no writeback;
- two fixed hazard shapes always stall: a same-register integer write right after a granted multiply, and an integer write that collides with a granted add's slot three cycles on.

The exact landing cycle of each unit's writeback, a write-after-write that is correctly allowed because it lands later, slot release through shifting during stalls, and the discarding of in-flight bookings by reset can only be shown by the bench's scripted instruction sequences.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Architectural register namespace shared by integer and FP instructions
    parameter int NUM_ARCH_REGS = 32;
    parameter int REG_IDX_W     = $clog2(NUM_ARCH_REGS);

    // Execution path selector of an issue candidate
    typedef enum logic [1:0] {
        OPK_INT  = 2'd0,
        OPK_LOAD = 2'd1,
        OPK_FADD = 2'd2,
        OPK_FMUL = 2'd3
    } op_kind_e;

    // One booked writeback cycle
    typedef struct packed {
        logic                 busy;
        logic [REG_IDX_W-1:0] dest;
    } wb_slot_t;

    // Destination that needs port booking and ordering
    function automatic logic dest_tracked(input logic wen, input logic [REG_IDX_W-1:0] dest);
        return wen && (dest != '0);
    endfunction

endpackage

// File: rtl/wb_slot_ring.sv
module wb_slot_ring
    import hzd_pkg::*;
#(
    parameter int RING_LEN = 9,
    parameter int LAT_W    = $clog2(RING_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 book,
    input  logic [LAT_W-1:0]     book_lat,
    input  logic [REG_IDX_W-1:0] book_dest,
    input  logic [LAT_W-1:0]     probe_lat,
    output logic                 probe_busy,
    output wb_slot_t             head
);

    // slots[i] describes the write landing i cycles from now
    wb_slot_t          slots [RING_LEN];
    logic [RING_LEN-1:0] busy_vec;

    for (genvar i = 0; i < RING_LEN; i++) begin : g_slot
        assign busy_vec[i] = slots[i].busy;

        if (i == RING_LEN - 1) begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)
                    slots[i] <= '0;
                else if (book && book_lat == LAT_W'(i + 1))
                    slots[i] <= '{busy: 1'b1, dest: book_dest};
                else
                    slots[i] <= '0;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)
                    slots[i] <= '0;
                else if (book && book_lat == LAT_W'(i + 1))
                    slots[i] <= '{busy: 1'b1, dest: book_dest};
                else
                    slots[i] <= slots[i + 1];
            end
        end
    end

    always_comb begin
        probe_busy = 1'b0;
        for (int i = 0; i < RING_LEN; i++)
            if (probe_lat == LAT_W'(i))
                probe_busy = busy_vec[i];
    end

    assign head = slots[0];

endmodule

// File: rtl/dest_pending_table.sv
module dest_pending_table
    import hzd_pkg::*;
#(
    parameter int NUM_REGS = NUM_ARCH_REGS,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [CNT_W-1:0] set_cnt,
    input  logic [IDX_W-1:0] query_idx,
    output logic [CNT_W-1:0] query_cnt
);

    // Cycles remaining until each register's outstanding write lands (0 = none)
    logic [CNT_W-1:0] remain [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        if (r == 0) begin : g_zero
            always_ff @(posedge clk) remain[r] <= '0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst)
                    remain[r] <= '0;
                else if (set_en && set_idx == IDX_W'(r))
                    remain[r] <= set_cnt;
                else if (remain[r] != '0)
                    remain[r] <= remain[r] - 1'b1;
            end
        end
    end

    always_comb begin
        query_cnt = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (query_idx == IDX_W'(r))
                query_cnt = remain[r];
    end

endmodule

// File: rtl/hazard_issue_ctrl.sv
module hazard_issue_ctrl
    import hzd_pkg::*;
#(
    parameter int LAT_INT  = 2,
    parameter int LAT_LOAD = 3,
    parameter int LAT_FADD = 5,
    parameter int LAT_FMUL = 8,
    parameter int RING_LEN = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic                 req_wen,
    input  logic [REG_IDX_W-1:0] req_dest,
    output logic                 issue_grant,
    output logic                 issue_stall,
    output logic                 wb_due,
    output logic [REG_IDX_W-1:0] wb_reg
);

    localparam int LAT_W = $clog2(RING_LEN);

    logic [LAT_W-1:0] lat_sel;
    logic             tracked;
    logic             port_busy;
    logic [LAT_W-1:0] pend_cnt;
    logic             waw_block;
    logic             hazard;
    logic             book;
    wb_slot_t         head_slot;

    always_comb begin
        unique case (op_kind_e'(req_kind))
            OPK_INT:  lat_sel = LAT_W'(LAT_INT);
            OPK_LOAD: lat_sel = LAT_W'(LAT_LOAD);
            OPK_FADD: lat_sel = LAT_W'(LAT_FADD);
            default:  lat_sel = LAT_W'(LAT_FMUL);
        endcase
    end

    assign tracked   = dest_tracked(req_wen, req_dest);
    assign waw_block = (pend_cnt != '0) && (lat_sel <= pend_cnt);
    assign hazard    = tracked && (port_busy || waw_block);

    assign issue_grant = req_valid && !hazard;
    assign issue_stall = req_valid && hazard;
    assign book        = issue_grant && tracked;

    wb_slot_ring #(
        .RING_LEN (RING_LEN),
        .LAT_W    (LAT_W)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .book       (book),
        .book_lat   (lat_sel),
        .book_dest  (req_dest),
        .probe_lat  (lat_sel),
        .probe_busy (port_busy),
        .head       (head_slot)
    );

    dest_pending_table #(
        .NUM_REGS (NUM_ARCH_REGS),
        .IDX_W    (REG_IDX_W),
        .CNT_W    (LAT_W)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .set_en    (book),
        .set_idx   (req_dest),
        .set_cnt   (lat_sel - 1'b1),
        .query_idx (req_dest),
        .query_cnt (pend_cnt)
    );

    assign wb_due = head_slot.busy;
    assign wb_reg = head_slot.dest;

endmodule

// File: rtl/hazard_issue_ctrl_chk.sv
module hazard_issue_ctrl_chk
    import hzd_pkg::*;
#(
    parameter int LAT_INT  = 2,
    parameter int LAT_FADD = 5,
    parameter int LAT_FMUL = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [1:0]           req_kind,
    input logic                 req_wen,
    input logic [REG_IDX_W-1:0] req_dest,
    input logic                 issue_grant,
    input logic                 issue_stall,
    input logic                 wb_due,
    input logic [REG_IDX_W-1:0] wb_reg
);

    logic                 mul_granted_q;
    logic [REG_IDX_W-1:0] mul_dest_q;
    logic [2:0]           fadd_hist;
    logic                 int_tracked_req;

    assign int_tracked_req = req_valid && req_kind == 2'd0 && req_wen && req_dest != '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mul_granted_q <= 1'b0;
            mul_dest_q    <= '0;
            fadd_hist     <= '0;
        end else begin
            mul_granted_q <= issue_grant && req_kind == 2'd3 && req_wen && req_dest != '0;
            mul_dest_q    <= req_dest;
            fadd_hist     <= {fadd_hist[1:0], issue_grant && req_kind == 2'd2 && req_wen && req_dest != '0};
        end
    end

    // R1
    grant_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(issue_grant && issue_stall));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!issue_grant && !issue_stall));

    // R7
    zero_reg_never_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wb_due |-> (wb_reg != '0));

    // R8
    reset_flush_chk: assert property (@(posedge clk)
        rst |=> !wb_due);

    if (LAT_INT < LAT_FMUL - 1) begin : g_waw_shape
        // R4
        waw_after_mul_chk: assert property (@(posedge clk) disable iff (rst)
            (mul_granted_q && int_tracked_req && req_dest == mul_dest_q) |-> issue_stall);
    end

    if (LAT_FADD == LAT_INT + 3) begin : g_port_shape
        // R3
        port_clash_after_add_chk: assert property (@(posedge clk) disable iff (rst)
            (fadd_hist[2] && int_tracked_req) |-> issue_stall);
    end

endmodule

bind hazard_issue_ctrl hazard_issue_ctrl_chk #(
    .LAT_INT  (LAT_INT),
    .LAT_FADD (LAT_FADD),
    .LAT_FMUL (LAT_FMUL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_wen     (req_wen),
    .req_dest    (req_dest),
    .issue_grant (issue_grant),
    .issue_stall (issue_stall),
    .wb_due      (wb_due),
    .wb_reg      (wb_reg)
);

// File: tb/sim_hazard_issue_ctrl.sv
module sim_hazard_issue_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic       req_wen = 1'b0;
    logic [4:0] req_dest = 5'd0;
    logic       issue_grant;
    logic       issue_stall;
    logic       wb_due;
    logic [4:0] wb_reg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    hazard_issue_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_wen     (req_wen),
        .req_dest    (req_dest),
        .issue_grant (issue_grant),
        .issue_stall (issue_stall),
        .wb_due      (wb_due),
        .wb_reg      (wb_reg)
    );

    typedef struct packed {
        logic       v;
        logic [1:0] kind;
        logic       wen;
        logic [4:0] dest;
        logic       exp_grant;
        logic       exp_stall;
        logic       exp_wb;
        logic [4:0] exp_wbreg;
        logic [3:0] tag;
    } row_t;

    // kinds: 0 int (L2), 1 load (L3), 2 fadd (L5), 3 fmul (L8)
    localparam int NROWS = 22;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 2'd3, 1'b1, 5'd5,  1'b1, 1'b0, 1'b0, 5'd0,  4'd2}, // c0  fmul r5 -> lands c8
        '{1'b1, 2'd0, 1'b1, 5'd5,  1'b0, 1'b1, 1'b0, 5'd0,  4'd4}, // c1  int r5 would overtake
        '{1'b1, 2'd2, 1'b1, 5'd6,  1'b1, 1'b0, 1'b0, 5'd0,  4'd3}, // c2  fadd r6 -> c7
        '{1'b1, 2'd1, 1'b1, 5'd7,  1'b1, 1'b0, 1'b0, 5'd0,  4'd2}, // c3  load r7 -> c6
        '{1'b1, 2'd0, 1'b1, 5'd8,  1'b0, 1'b1, 1'b0, 5'd0,  4'd3}, // c4  int -> c6 taken
        '{1'b1, 2'd0, 1'b1, 5'd8,  1'b0, 1'b1, 1'b0, 5'd0,  4'd3}, // c5  int -> c7 taken
        '{1'b1, 2'd0, 1'b1, 5'd8,  1'b0, 1'b1, 1'b1, 5'd7,  4'd6}, // c6  int -> c8 taken
        '{1'b1, 2'd0, 1'b1, 5'd8,  1'b1, 1'b0, 1'b1, 5'd6,  4'd6}, // c7  int -> c9 free
        '{1'b1, 2'd0, 1'b1, 5'd5,  1'b1, 1'b0, 1'b1, 5'd5,  4'd5}, // c8  r5 write lands now
        '{1'b1, 2'd3, 1'b1, 5'd0,  1'b1, 1'b0, 1'b1, 5'd8,  4'd7}, // c9  fmul r0: no booking
        '{1'b1, 2'd0, 1'b0, 5'd9,  1'b1, 1'b0, 1'b1, 5'd5,  4'd7}, // c10 no write enable
        '{1'b1, 2'd2, 1'b1, 5'd10, 1'b1, 1'b0, 1'b0, 5'd0,  4'd2}, // c11 fadd r10 -> c16
        '{1'b1, 2'd3, 1'b1, 5'd10, 1'b1, 1'b0, 1'b0, 5'd0,  4'd5}, // c12 fmul r10 -> c20 later
        '{1'b1, 2'd2, 1'b1, 5'd11, 1'b1, 1'b0, 1'b0, 5'd0,  4'd2}, // c13 fadd r11 -> c18
        '{1'b1, 2'd1, 1'b1, 5'd10, 1'b0, 1'b1, 1'b0, 5'd0,  4'd4}, // c14 load r10 before c20
        '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0,  4'd1}, // c15 idle
        '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 5'd10, 4'd2}, // c16
        '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0,  4'd7}, // c17 r0 fmul dropped
        '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 5'd11, 4'd2}, // c18
        '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0,  4'd2}, // c19
        '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 5'd10, 4'd5}, // c20
        '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd0,  4'd2}  // c21
    };

    task automatic drive(input logic v, input logic [1:0] k, input logic w, input logic [4:0] d);
        @(negedge clk);
        req_valid = v;
        req_kind  = k;
        req_wen   = w;
        req_dest  = d;
        #1;
    endtask

    task automatic chk_issue(input string tag, input logic eg, input logic es);
        n_cmp++;
        if (issue_grant !== eg || issue_stall !== es) begin
            n_bad++;
            $display("FAIL %s issue: grant=%b stall=%b expected grant=%b stall=%b",
                     tag, issue_grant, issue_stall, eg, es);
        end
    endtask

    task automatic chk_wb(input string tag, input logic ew, input logic [4:0] er);
        n_cmp++;
        if (wb_due !== ew || (ew && wb_reg !== er)) begin
            n_bad++;
            $display("FAIL %s writeback: due=%b reg=%0d expected due=%b reg=%0d",
                     tag, wb_due, wb_reg, ew, er);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: quiet outputs right after reset
        chk_issue("R8", 1'b0, 1'b0);
        chk_wb("R8", 1'b0, 5'd0);

        // R1 R2 R3 R4 R5 R6 R7: scripted sequence
        for (int i = 0; i < NROWS; i++) begin
            drive(TBL[i].v, TBL[i].kind, TBL[i].wen, TBL[i].dest);
            chk_issue($sformatf("R%0d row%0d", TBL[i].tag, i), TBL[i].exp_grant, TBL[i].exp_stall);
            chk_wb($sformatf("R2 row%0d", i), TBL[i].exp_wb, TBL[i].exp_wbreg);
        end

        // R5: back-to-back integer writes to one register land in order
        drive(1'b1, 2'd0, 1'b1, 5'd12);
        chk_issue("R5 first", 1'b1, 1'b0);
        drive(1'b1, 2'd0, 1'b1, 5'd12);
        chk_issue("R5 second", 1'b1, 1'b0);
        drive(1'b0, 2'd0, 1'b0, 5'd0);
        chk_wb("R5 first lands", 1'b1, 5'd12);
        drive(1'b0, 2'd0, 1'b0, 5'd0);
        chk_wb("R5 second lands", 1'b1, 5'd12);
        drive(1'b0, 2'd0, 1'b0, 5'd0);
        chk_wb("R5 drained", 1'b0, 5'd0);

        // R8: reset discards in-flight bookings
        drive(1'b1, 2'd3, 1'b1, 5'd3);
        chk_issue("R8 pre fmul", 1'b1, 1'b0);
        drive(1'b1, 2'd2, 1'b1, 5'd4);
        chk_issue("R8 pre fadd", 1'b1, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int k = 0; k < 10; k++) begin
            if (k == 0) begin
                req_valid = 1'b1; req_kind = 2'd0; req_wen = 1'b1; req_dest = 5'd3;
                #1;
                chk_issue("R8 post int r3", 1'b1, 1'b0);
            end else begin
                drive(1'b0, 2'd0, 1'b0, 5'd0);
            end
            chk_wb($sformatf("R8 post k%0d", k), (k == 2), 5'd3);
        end

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule